// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is a single 16-bit timer channel. An up-counter advances on a count tick. The tick comes from a free-running divider of the system clock or from rising edges on an external clock pin. The channel has four general registers. Each one can be set as a compare register, which acts on an output pin when the counter reaches its value, or as a capture register, which stores the counter when its pin shows a chosen edge.

Registers 2 and 3 can be turned into shadows of registers 0 and 1. A capture master then pushes its previous value into its shadow. A compare master reloads itself from its shadow on every match, so software can stage the next value at any time. The counter can be reset by the event of any one register, which sets the period. A PWM output is high while the counter is below register 1.

Software uses a write port and a combinational read port on eight word addresses. Every match or capture also raises a sticky flag on a dedicated output.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset the counter reads 0, every general register reads 0xFFFF, the control word (address 0) reads 0x0007, the mode word (address 1) reads 0, and the flags, compare outputs and PWM output are all 0.
- R2: Control bits [2:0] select the tick. A value k from 0 to 6 gives one counter increment every 2^k clocks. The value 7 gives one increment for each rising edge of ext_clk; that increment lands three clocks after the pin rises. With no tick the counter holds.
- R3: Control bits [5:3] hold a clear source c. When c is 1 to 4, the event of register c-1 makes the counter go to 0 instead of advancing. For a compare register the counter therefore runs from 0 up to its value and then returns to 0, giving a period of value+1 ticks.
- R4: Mode nibble k (bits [4k+3:4k]) configures register k. Bit 3 = 0 selects compare. A compare match occurs on a tick while the counter equals the register. On a match, action bits [1:0] leave cmp_out[k] unchanged (0), drive it to 0 (1), drive it to 1 (2) or invert it (3). The pin changes on the clock edge of that tick.
- R5: Mode bit 3 = 1 selects capture. Action bit 0 enables rising edges and bit 1 enables falling edges of cap_in[k]. The register stores the counter three clocks after an enabled pin change. A disabled edge leaves the register unchanged.
- R6: Control bit 6 (bit 7) pairs register 2 (register 3) as shadow of register 0 (register 1). A capture into the master copies the master's previous value into the shadow, and the shadow itself neither matches nor captures.
- R7: With the pairing on and the master in compare mode, each match of the master loads it from its shadow. A shadow write between matches only reaches the master at the next match.
- R8: Flag k (irq_flags[k], read at address 2) is set by every match or capture of register k. It stays set until software writes 1 to bit k at address 2. Writing 0 bits leaves flags unchanged.
- R9: When control bit 8 is set, pwm_out is high in the clock after each cycle in which the counter is below register 1, and low otherwise. When the bit is clear, pwm_out is 0.
- R10: A capture register chosen as clear source stores the counter and clears the counter on the same edge.
- R11: A write to address 3 loads the counter on that edge and takes precedence over counting and clearing; addresses 4 to 7 write registers 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| cap_in | input | 4 | Asynchronous capture pins, one per register |
| ext_clk | input | 1 | Asynchronous external count clock |
| cmp_out | output | 4 | Compare output pins, one per register |
| pwm_out | output | 1 | PWM output |
| irq_flags | output | 4 | Sticky match/capture flags |

## Verification
A register write is visible on the read port at the falling edge after the edge that commits it. A capture result or an external-clock increment is due three clocks after the pin change, so the bench checks a capture both at two clocks (not yet stored) and at three clocks (stored). Compare pins, flags and buffer reloads move on the same edge as the tick that matches. PWM trails the counter by exactly one clock. Every check is queued by the driver at a falling edge and read by the monitor one nanosecond later, before the next rising edge.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int NREG   = 4;
    localparam int NPAIR  = NREG / 2;
    localparam int PSC_W  = 6;
    localparam logic [2:0] SEL_EXT = 3'd7;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_FLAG = 3'd2;
    localparam logic [2:0] A_CNT  = 3'd3;

    typedef struct packed {
        logic             pwm;
        logic [NPAIR-1:0] buf_en;
        logic [2:0]       clr;
        logic [2:0]       sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{pwm: 1'b0, buf_en: '0, clr: 3'd0, sel: SEL_EXT};
endpackage

// File: rtl/cct_edge.sv
module cct_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pins;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign lvl = sy_q.s2;
    assign chg = sy_q.s2 ^ sy_q.prev;
endmodule

// File: rtl/cct_prescale.sv
module cct_prescale
    import cct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       ext_rise,
    output logic       tick
);
    logic [PSC_W-1:0] psc_d, psc_q;
    logic [PSC_W-1:0] mask;

    always_comb begin
        psc_d = psc_q + 1'b1;
        mask  = PSC_W'((1 << sel) - 1);
        if (sel == SEL_EXT) tick = ext_rise;
        else                tick = ((psc_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
    import cct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic [3:0]    cap_in,
    input  logic          ext_clk,
    output logic [3:0]    cmp_out,
    output logic          pwm_out,
    output logic [3:0]    irq_flags
);
    localparam int NR = NREG;
    localparam int MW = 4 * NR;

    typedef struct packed {
        ctrl_t                 ctrl;
        logic [MW-1:0]         mode;
        logic [NR-1:0]         flags;
        logic [CW-1:0]         cnt;
        logic [NR-1:0][CW-1:0] gr;
        logic [NR-1:0]         outp;
        logic                  pwm;
    } st_t;

    st_t st_d, st_q;

    logic [NR:0]   pin_lvl, pin_chg;
    logic [NR-1:0] cap_rise, cap_fall;
    logic          ext_rise, tick;
    logic [NR-1:0] hit_cmp, hit_cap, slave, master;
    logic          clr_evt, cnt_wr;

    cct_edge #(.N(NR + 1)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pins ({ext_clk, cap_in}),
        .lvl  (pin_lvl),
        .chg  (pin_chg)
    );

    assign cap_rise = pin_chg[NR-1:0] & pin_lvl[NR-1:0];
    assign cap_fall = pin_chg[NR-1:0] & ~pin_lvl[NR-1:0];
    assign ext_rise = pin_chg[NR] & pin_lvl[NR];

    cct_prescale u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (st_q.ctrl.sel),
        .ext_rise(ext_rise),
        .tick    (tick)
    );

    assign slave  = {st_q.ctrl.buf_en, {NPAIR{1'b0}}};
    assign master = {{NPAIR{1'b0}}, st_q.ctrl.buf_en};
    assign cnt_wr = wr_en && (wr_addr == A_CNT);

    // event detection per register
    always_comb begin
        hit_cmp = '0;
        hit_cap = '0;
        clr_evt = 1'b0;
        for (int k = 0; k < NR; k++) begin
            if (!slave[k]) begin
                if (!st_q.mode[4*k+3])
                    hit_cmp[k] = tick && (st_q.cnt == st_q.gr[k]);
                else
                    hit_cap[k] = (cap_rise[k] && st_q.mode[4*k]) ||
                                 (cap_fall[k] && st_q.mode[4*k+1]);
            end
            if ((int'(st_q.ctrl.clr) == k + 1) && (hit_cmp[k] || hit_cap[k]))
                clr_evt = 1'b1;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  st_d.ctrl  = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
                A_MODE:  st_d.mode  = wr_data[MW-1:0];
                A_FLAG:  st_d.flags = st_q.flags & ~wr_data[NR-1:0];
                A_CNT:   st_d.cnt   = wr_data;
                default: st_d.gr[wr_addr[1:0]] = wr_data;
            endcase
        end
        if (!cnt_wr) begin
            if (clr_evt)   st_d.cnt = '0;
            else if (tick) st_d.cnt = st_q.cnt + 1'b1;
        end
        for (int k = 0; k < NR; k++) begin
            if (hit_cmp[k]) begin
                case (st_q.mode[4*k +: 2])
                    2'd1:    st_d.outp[k] = 1'b0;
                    2'd2:    st_d.outp[k] = 1'b1;
                    2'd3:    st_d.outp[k] = ~st_q.outp[k];
                    default: st_d.outp[k] = st_q.outp[k];
                endcase
                if (master[k]) st_d.gr[k] = st_q.gr[(k + NPAIR) % NR];
            end
            if (hit_cap[k]) begin
                st_d.gr[k] = st_q.cnt;
                if (master[k]) st_d.gr[(k + NPAIR) % NR] = st_q.gr[k];
            end
        end
        st_d.flags = st_d.flags | hit_cmp | hit_cap;
        st_d.pwm   = st_q.ctrl.pwm && (st_q.cnt < st_q.gr[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RST;
            st_q.gr   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = CW'(st_q.ctrl);
            A_MODE:  rd_data = CW'(st_q.mode);
            A_FLAG:  rd_data = CW'(st_q.flags);
            A_CNT:   rd_data = st_q.cnt;
            default: rd_data = st_q.gr[rd_addr[1:0]];
        endcase
    end

    assign cmp_out   = st_q.outp;
    assign pwm_out   = st_q.pwm;
    assign irq_flags = st_q.flags;
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [CW-1:0] wr_data,
    input logic [3:0]    irq_flags,
    input logic [3:0]    cmp_out,
    input logic          tick,
    input logic [3:0]    hit_cmp,
    input logic [3:0]    hit_cap,
    input logic          clr_evt,
    input logic [CW-1:0] cnt_now
);
    logic       cnt_wr;
    logic [3:0] w1c, keep, hits;

    assign cnt_wr = wr_en && (wr_addr == 3'd3);
    assign w1c    = (wr_en && wr_addr == 3'd2) ? wr_data[3:0] : 4'd0;
    assign keep   = irq_flags & ~w1c;
    assign hits   = hit_cmp | hit_cap;

    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_evt && !cnt_wr) |=> $stable(cnt_now));

    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_evt && !cnt_wr) |=> (cnt_now == CW'($past(cnt_now) + 1'b1)));

    a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !cnt_wr) |=> (cnt_now == '0));

    a_r4_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cmp == 4'd0) |=> $stable(cmp_out));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (keep != 4'd0) |=> ((irq_flags & $past(keep)) == $past(keep)));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != 4'd0) |=> ((irq_flags & $past(hits)) == $past(hits)));

    a_r11_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_now == $past(wr_data)));
endmodule

bind cc_timer_chan cct_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_flags(irq_flags),
    .cmp_out  (cmp_out),
    .tick     (tick),
    .hit_cmp  (hit_cmp),
    .hit_cap  (hit_cap),
    .clr_evt  (clr_evt),
    .cnt_now  (st_q.cnt)
);

// File: tb/cc_timer_chan_tb.sv
module cc_timer_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  cap_in = '0;
    logic        ext_clk = 1'b0;
    logic [3:0]  cmp_out;
    logic        pwm_out;
    logic [3:0]  irq_flags;

    cc_timer_chan u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .ext_clk(ext_clk), .cmp_out(cmp_out),
        .pwm_out(pwm_out), .irq_flags(irq_flags)
    );

    always #10 clk = ~clk;

    // src: 0 read port, 1 cmp_out, 2 pwm_out, 3 irq_flags
    // kind: 0 equal, 1 store as base, 2 equal to base + exp
    typedef struct {
        int          src;
        logic [2:0]  addr;
        logic [15:0] exp;
        int          kind;
        string       tag;
    } item_t;

    item_t q[$];
    int n_push = 0, n_done = 0, n_chk = 0, n_err = 0;
    logic [15:0] base = '0;
    bit done = 1'b0;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // monitor
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                item_t it;
                logic [15:0] act, want;
                it = q.pop_front();
                rd_addr = it.addr;
                #1;
                case (it.src)
                    1:       act = {12'd0, cmp_out};
                    2:       act = {15'd0, pwm_out};
                    3:       act = {12'd0, irq_flags};
                    default: act = rd_data;
                endcase
                if (it.kind == 1) begin
                    base = act;
                end else begin
                    want = (it.kind == 2) ? base + it.exp : it.exp;
                    n_chk++;
                    if (act !== want) begin
                        n_err++;
                        $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, want);
                    end
                end
            end
            n_done++;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic chk(int src, logic [2:0] addr, logic [15:0] exp, string tag, int kind = 0);
        item_t it;
        it.src = src; it.addr = addr; it.exp = exp; it.kind = kind; it.tag = tag;
        q.push_back(it);
        n_push++;
        wait (n_done == n_push);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        ext_clk = 1'b1; cyc(4);
        ext_clk = 1'b0; cyc(4);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1
        chk(0, 3'd3, 16'h0000, "R1 counter");
        chk(0, 3'd4, 16'hFFFF, "R1 reg0");
        chk(0, 3'd7, 16'hFFFF, "R1 reg3");
        chk(0, 3'd0, 16'h0007, "R1 control");
        chk(0, 3'd1, 16'h0000, "R1 mode");
        chk(3, 3'd0, 16'h0000, "R1 flags");
        chk(1, 3'd0, 16'h0000, "R1 cmp_out");
        chk(2, 3'd0, 16'h0000, "R1 pwm_out");

        // R11 counter load
        wr(3'd3, 16'h1234);
        chk(0, 3'd3, 16'h1234, "R11 counter load");

        // R2 external clock
        pulse(); pulse(); pulse();
        chk(0, 3'd3, 16'h1237, "R2 ext clock three edges");
        cyc(6);
        chk(0, 3'd3, 16'h1237, "R2 hold without edges");

        // R2 divide by 4 and by 1
        wr(3'd0, 16'h0002);
        chk(0, 3'd3, 16'h0, "R2 base", 1);
        cyc(16);
        chk(0, 3'd3, 16'd4, "R2 divide by 4", 2);
        wr(3'd0, 16'h0000);
        chk(0, 3'd3, 16'h0, "R2 base", 1);
        cyc(10);
        chk(0, 3'd3, 16'd10, "R2 divide by 1", 2);

        // R3 clear on compare of reg0, period 5
        wr(3'd0, 16'h000F);
        wr(3'd2, 16'h000F);
        wr(3'd4, 16'h0004);
        wr(3'd3, 16'h0000);
        wr(3'd0, 16'h0008);
        for (int i = 0; i < 12; i++) begin
            chk(0, 3'd3, 16'(i % 5), "R3 clear on match sequence");
            @(negedge clk);
        end
        wr(3'd0, 16'h000F);
        chk(3, 3'd0, 16'h0001, "R8 match sets flag");
        wr(3'd2, 16'h000F);
        chk(3, 3'd0, 16'h0000, "R8 write one clears");

        // R4 compare actions
        wr(3'd0, 16'h0007);
        wr(3'd4, 16'h0001);
        wr(3'd5, 16'h0002);
        wr(3'd1, 16'h0032);
        wr(3'd3, 16'h0000);
        pulse();
        chk(1, 3'd0, 16'h0000, "R4 no match yet");
        pulse();
        chk(1, 3'd0, 16'h0001, "R4 drive one");
        pulse();
        chk(1, 3'd0, 16'h0003, "R4 toggle high");
        wr(3'd1, 16'h0031);
        wr(3'd3, 16'h0001);
        pulse();
        chk(1, 3'd0, 16'h0002, "R4 drive zero");
        chk(3, 3'd0, 16'h0003, "R8 flags of two matches");
        wr(3'd2, 16'h0001);
        chk(3, 3'd0, 16'h0002, "R8 selective clear");
        wr(3'd2, 16'h0000);
        chk(3, 3'd0, 16'h0002, "R8 zero write keeps flag");
        wr(3'd3, 16'h0002);
        pulse();
        chk(1, 3'd0, 16'h0000, "R4 toggle low");

        // R5 capture edges
        wr(3'd2, 16'h000F);
        wr(3'd1, 16'h0900);
        wr(3'd3, 16'h0050);
        cap_in[2] = 1'b1;
        cyc(2);
        chk(0, 3'd6, 16'hFFFF, "R5 not yet at two clocks");
        cyc(1);
        chk(0, 3'd6, 16'h0050, "R5 rising capture at three clocks");
        wr(3'd3, 16'h0060);
        cap_in[2] = 1'b0;
        cyc(4);
        chk(0, 3'd6, 16'h0050, "R5 falling ignored");
        wr(3'd1, 16'hB900);
        wr(3'd3, 16'h0070);
        cap_in[3] = 1'b1;
        cyc(3);
        chk(0, 3'd7, 16'h0070, "R5 both edges rise");
        wr(3'd3, 16'h0071);
        cap_in[3] = 1'b0;
        cyc(3);
        chk(0, 3'd7, 16'h0071, "R5 both edges fall");
        wr(3'd1, 16'hBA00);
        wr(3'd3, 16'h0080);
        cap_in[2] = 1'b1;
        cyc(4);
        chk(0, 3'd6, 16'h0050, "R5 rising ignored in falling mode");
        cap_in[2] = 1'b0;
        cyc(3);
        chk(0, 3'd6, 16'h0080, "R5 falling capture");
        chk(3, 3'd0, 16'h000C, "R8 capture flags");

        // R6 capture buffering
        wr(3'd2, 16'h000F);
        wr(3'd1, 16'h0009);
        wr(3'd0, 16'h0047);
        wr(3'd3, 16'h0100);
        cap_in[0] = 1'b1;
        cyc(3);
        chk(0, 3'd4, 16'h0100, "R6 master capture");
        chk(0, 3'd6, 16'h0001, "R6 shadow gets old master");
        cap_in[0] = 1'b0;
        cyc(3);
        wr(3'd3, 16'h0200);
        cap_in[0] = 1'b1;
        cyc(3);
        chk(0, 3'd4, 16'h0200, "R6 second capture");
        chk(0, 3'd6, 16'h0100, "R6 shadow holds previous");

        // R7 compare reload
        wr(3'd1, 16'h0000);
        wr(3'd4, 16'h0003);
        wr(3'd6, 16'h0007);
        wr(3'd3, 16'h0003);
        pulse();
        chk(0, 3'd4, 16'h0007, "R7 reload on match");
        wr(3'd6, 16'h000A);
        wr(3'd3, 16'h0005);
        pulse();
        chk(0, 3'd4, 16'h0007, "R7 mid-period write waits");
        wr(3'd3, 16'h0007);
        pulse();
        chk(0, 3'd4, 16'h000A, "R7 staged value at next match");

        // R9 PWM, period 10, high for 3
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h000F);
        wr(3'd4, 16'h0009);
        wr(3'd5, 16'h0003);
        wr(3'd0, 16'h010F);
        wr(3'd3, 16'h0000);
        cyc(2);
        wr(3'd0, 16'h0108);
        chk(2, 3'd0, 16'h0001, "R9 pwm high at zero");
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            chk(2, 3'd0, (((n - 1) % 10) < 3) ? 16'h1 : 16'h0, "R9 pwm sequence");
        end
        wr(3'd0, 16'h000F);
        cyc(2);
        chk(2, 3'd0, 16'h0000, "R9 pwm off");

        // R10 capture clears counter
        wr(3'd1, 16'h9000);
        wr(3'd0, 16'h0027);
        wr(3'd3, 16'h0300);
        cap_in[3] = 1'b1;
        cyc(3);
        chk(0, 3'd7, 16'h0300, "R10 captured value");
        chk(0, 3'd3, 16'h0000, "R10 counter cleared");

        done = 1'b1;
        finish_run();
    end
endmodule